// File: doc/BRIEF.md
# Dual-Clock Byte Storage and Serial Shifter

This block takes a byte in parallel and sends it out one bit at a time. A storage register captures the parallel input bus on its own clock. A separate shift register is clocked independently and moves data toward a single serial output. A shifted-out word can therefore run on one clock while the next byte is captured on the other.

An active-low load control places the stored byte into the shift stages without waiting for a shift clock edge. The load acts as a level override: while it is held low, the shift stages keep tracking the storage register and shift clock edges do nothing. When load is released, the last byte presented stays in place until the next shift edge.

An active-low master reset clears the shift stages. It takes priority over load and leaves the storage register unchanged. With both controls high, each rising shift clock edge moves every bit one stage toward the output end. The serial input enters the first stage and the last stage drives the output.

Top module: `dual_clock_shifter`

## Requirements
- R1: While `mrst_n` is low, all shift stages read zero, so `ser_out` is 0. After release, the stages stay zero until they are loaded or shifted.
- R2: When `mrst_n` and `ld_n` are both low, reset wins and the stages read zero. If `mrst_n` is released while `ld_n` is still low, the stages take the stored byte.
- R3: The storage register captures `par_in` on the rising edge of `store_clk`, and only then. A change on `par_in` between edges has no effect on what a later load delivers.
- R4: Asserting `mrst_n` leaves the storage register unchanged. A load after a reset still delivers the byte captured before the reset.
- R5: Driving `ld_n` low makes `ser_out` show bit 7 of the stored byte with no `shift_clk` edge needed.
- R6: While `ld_n` is low, `shift_clk` edges do not change the stages. A new byte captured by `store_clk` during that time appears at once.
- R7: With `ld_n` and `mrst_n` high, each rising `shift_clk` edge moves stage i to stage i+1 and places `ser_in` into stage 0. `ser_out` is stage 7, so the stored byte leaves MSB first.
- R8: After `ld_n` returns high, the loaded byte stays in the stages until the next `shift_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| store_clk | input | 1 | Storage register clock, rising edge |
| shift_clk | input | 1 | Shift register clock, rising edge |
| mrst_n | input | 1 | Asynchronous clear of the shift stages, active low |
| ld_n | input | 1 | Asynchronous level-sensitive load from storage, active low |
| par_in | input | 8 | Parallel data captured by the storage register |
| ser_in | input | 1 | Serial data entering stage 0 |
| ser_out | output | 1 | Serial data from stage 7 |

## Verification
Some rules are checked by assertions at every shift clock edge:
- the stages read zero during reset;
- the stages equal the stored byte while load is low;
- each undisturbed shift step moves the stages by exactly one position and takes in the serial bit.

The assertions also check that each storage clock edge captures the input bus. Other behaviour appears only through the bench's scenarios:
- that a load shows up before any shift edge;
- that the loaded byte survives the release of load, and that reset spares the storage register;
- that input bus changes between storage edges are ignored.

The bench sweeps all 256 byte values through both the parallel path and the serial path.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  // One shift step: every stage moves up one position, the serial bit enters stage 0.
  function automatic logic [7:0] step8(input logic [7:0] cur, input logic bit_in);
    return {cur[6:0], bit_in};
  endfunction

endpackage

// File: rtl/dcs_store.sv
module dcs_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Byte-wide holding register. It has no reset by design: master reset must not touch it.
  always_ff @(posedge clk) begin
    q <= d;
  end

endmodule

// File: rtl/dcs_override.sv
module dcs_override #(
  parameter int W = 8
) (
  input  logic         shift_clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] stored,
  output logic         ovr_n,
  output logic         held,
  output logic [W-1:0] snap
);

  // The override is active when either control is low.
  assign ovr_n = rst_n & load_n;

  // Transparent while the override is active. Reset forces zero, otherwise the stored byte passes.
  always_latch begin
    if (!ovr_n) snap = rst_n ? stored : '0;
  end

  // Set asynchronously by the override. Cleared at the first shift edge after release,
  // when the shift flops take over the snapshot.
  always_ff @(posedge shift_clk or negedge ovr_n) begin
    if (!ovr_n) held <= 1'b1;
    else        held <= 1'b0;
  end

endmodule

// File: rtl/dcs_shifter.sv
module dcs_shifter #(
  parameter int W = 8
) (
  input  logic         shift_clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         held,
  input  logic [W-1:0] snap,
  input  logic [W-1:0] stored,
  input  logic         sin,
  output logic [W-1:0] stages
);

  localparam int LAST = W - 1;

  logic [W-1:0] q;
  logic [W-1:0] nxt;

  // Visible stage values: the snapshot while it is newer than the flops.
  assign stages = held ? snap : q;

  generate
    if (W == 8) begin : g_byte
      assign nxt = dcs_pkg::step8(stages, sin);
    end else begin : g_wide
      assign nxt = {stages[LAST-1:0], sin};
    end
  endgenerate

  always_ff @(posedge shift_clk) begin
    q <= nxt;
  end

  // R1 R2
  always_ff @(posedge shift_clk) begin
    if (!rst_n) begin
      reset_zero_chk: assert (stages == '0);
    end
  end

  // R6
  load_follow_chk: assert property (@(posedge shift_clk) disable iff (!rst_n)
    !load_n |-> stages == stored);

  // R7
  shift_step_chk: assert property (@(posedge shift_clk) disable iff (!rst_n)
    (!held && load_n && $past(load_n) && $past(rst_n))
      |-> stages == {$past(stages[LAST-1:0]), $past(sin)});

endmodule

// File: rtl/dual_clock_shifter.sv
module dual_clock_shifter #(
  parameter int W = 8
) (
  input  logic         store_clk,
  input  logic         shift_clk,
  input  logic         mrst_n,
  input  logic         ld_n,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic         ser_out
);

  localparam int LAST = W - 1;

  logic [W-1:0] stored;
  logic [W-1:0] snap;
  logic [W-1:0] stages;
  logic         ovr_n;
  logic         held;

  dcs_store #(.W(W)) u_store (
    .clk (store_clk),
    .d   (par_in),
    .q   (stored)
  );

  dcs_override #(.W(W)) u_ovr (
    .shift_clk (shift_clk),
    .rst_n     (mrst_n),
    .load_n    (ld_n),
    .stored    (stored),
    .ovr_n     (ovr_n),
    .held      (held),
    .snap      (snap)
  );

  dcs_shifter #(.W(W)) u_shift (
    .shift_clk (shift_clk),
    .rst_n     (mrst_n),
    .load_n    (ld_n),
    .held      (held),
    .snap      (snap),
    .stored    (stored),
    .sin       (ser_in),
    .stages    (stages)
  );

  assign ser_out = stages[LAST];

  // R3
  store_capture_chk: assert property (@(posedge store_clk) disable iff (!mrst_n)
    1'b1 |=> stored == $past(par_in));

endmodule

// File: tb/tb_dual_clock_shifter.sv
module tb_dual_clock_shifter;

  logic clk = 0;
  logic store_clk = 0, shift_clk = 0, mrst_n = 0, ld_n = 1, ser_in = 0;
  logic [7:0] par_in = 0;
  logic ser_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_clock_shifter dut (
    .store_clk (store_clk), .shift_clk (shift_clk), .mrst_n (mrst_n), .ld_n (ld_n),
    .par_in (par_in), .ser_in (ser_in), .ser_out (ser_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_store(input logic [7:0] v);
    par_in = v; #5 store_clk = 1; #5 store_clk = 0; #5;
  endtask

  task automatic pulse_shift(input logic b);
    ser_in = b; #5 shift_clk = 1; #5 shift_clk = 0; #5;
  endtask

  // The stages leave MSB first, so the expected output bits are e[7], e[6], ... e[0].
  task automatic read_byte(input string req, input logic [7:0] e);
    for (int i = 0; i < 8; i++) begin
      chk(req, ser_out, e[7-i]);
      pulse_shift(1'b0);
    end
  endtask

  task automatic do_load();
    #5 ld_n = 0; #5 ld_n = 1; #5;
  endtask

  initial begin
    #5;
    // R1: the output is zero while reset is held, and the stages stay zero after release
    chk("R1", ser_out, 1'b0);
    pulse_shift(1'b1);
    chk("R1", ser_out, 1'b0);
    mrst_n = 1; #5;
    read_byte("R1", 8'h00);

    // Exhaustive sweep of the parallel path. R3 R5 R8 R7
    for (int v = 0; v < 256; v++) begin
      pulse_store(v[7:0]);
      do_load();
      read_byte("R8", v[7:0]);
    end

    // Exhaustive sweep of the serial path. R7
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < 8; i++) pulse_shift(p[7-i]);
      read_byte("R7", p[7:0]);
    end

    // R5: a load acts without any shift edge
    pulse_store(8'h80);
    chk("R5", ser_out, 1'b0);
    ld_n = 0; #3;
    chk("R5", ser_out, 1'b1);

    // R6: shift edges are ignored while load is low, and a new stored byte shows at once
    pulse_shift(1'b0);
    chk("R6", ser_out, 1'b1);
    pulse_store(8'h3C);
    chk("R6", ser_out, 1'b0);
    pulse_shift(1'b1);
    ld_n = 1; #5;
    read_byte("R6", 8'h3C);

    // R3: a bus change with no storage edge is not captured
    pulse_store(8'hC3);
    par_in = 8'h5A; #10;
    do_load();
    read_byte("R3", 8'hC3);

    // R2: reset wins over load. Releasing reset while load is still low gives the stored byte.
    pulse_store(8'hFF);
    mrst_n = 0; ld_n = 0; #5;
    chk("R2", ser_out, 1'b0);
    mrst_n = 1; #5;
    chk("R2", ser_out, 1'b1);
    ld_n = 1; #5;
    read_byte("R2", 8'hFF);

    // R4: reset leaves the storage register unchanged
    pulse_store(8'hA5);
    mrst_n = 0; #5;
    chk("R4", ser_out, 1'b0);
    mrst_n = 1; #5;
    do_load();
    read_byte("R4", 8'hA5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule